// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the host-facing register file of a two-channel serial communications controller. A byte-wide bus with a two-bit address reaches it. The low address bit chooses between the control port and the data port. The next bit chooses the channel. Each channel has sixteen write registers and sixteen read registers, but only two bus locations. The other registers are reached indirectly through a pointer that lives in register 0 of each channel.

The block keeps the transmit and receive byte buffers, the status bits that report them, the pending interrupt flags and the channel reset commands. From the configuration registers it decodes the line parameters that a serializer needs: the divisor from the input clock to one bit time, the character length, the stop bit count and the parity. It does not serialize bits, recover clocks or run synchronous modes.

Top module: `scc_regif`

## Requirements
- R1: `bus_addr[0]`=0 is the control port and 1 is the data port. `bus_addr[1]`=1 addresses channel A (port index 1) and 0 addresses channel B (port index 0). An access touches only the channel it addresses.
- R2: A control write while the pointer is 0 loads the pointer. Bits 2:0 give the register index, and 8 is added when bits 5:3 equal 001. Any control read or write made while the pointer is nonzero uses register[pointer] and then returns the pointer to 0. A control read made while the pointer is 0 returns RR0.
- R3: Command field bits 5:3 of a pointer-0 control write: 101 clears the channel's transmit-pending flag. 111 clears the receive-pending flag if it is set, and otherwise clears the transmit-pending flag. The pending flags are read as RR3 of channel A, with bit 1 = B transmit, bit 2 = B receive, bit 4 = A transmit and bit 5 = A receive. RR3 of channel B reads 0.
- R4: A write to WR9 of either channel acts on bits 7:6. 01 resets channel B, 10 resets channel A, 11 resets both, and 00 resets neither.
- R5: After `rst` or a channel reset, every write register is 0 except WR4=0x04, WR9=0xC0, WR11=0x08, WR14=0x30 and WR15=0xF8. RR0 reads 0x44, RR1 reads 0x07, RR2 and RR3 read 0, the receive buffer holds 0, and the line outputs show 5 bits, 1 stop bit, no parity and divisor 4.
- R6: A data write with WR5 bit 3 set pulses `tx_valid` for one cycle after the write edge, with the byte on `tx_data`. It also sets RR0 bit 2, RR1 bit 0 and the transmit-pending flag. With WR5 bit 3 clear, a data write has no effect.
- R7: `rx_ready` equals WR3 bit 0 AND NOT RR0 bit 0. A byte offered while `rx_ready` is high is stored, and it sets RR0 bit 0 and the receive-pending flag. A byte offered while `rx_ready` is low is dropped. A data read returns the stored byte and clears RR0 bit 0.
- R8: `cfg_bits` decodes WR5 bits 6:5 as 00=5, 01=7, 10=6, 11=8. `cfg_par_en` is WR4 bit 0 and `cfg_par_even` is WR4 bit 1. `cfg_two_stop` is set only when WR4 bits 3:2 equal 11.
- R9: `cfg_div` is the number of input clocks per bit, 2*({WR13,WR12}+2)*P. P is 1, 16, 32 or 64 for WR4 bits 7:6 = 00, 01, 10, 11.
- R10: Line outputs are recomputed after a write to WR4, WR5, WR12 or WR13, and after a channel reset. The new values and a one-cycle `cfg_valid` pulse appear one cycle after the write edge. No other access refreshes them or pulses `cfg_valid`.
- R11: A write to WR2 is mirrored into RR2 of the same channel. Read registers other than RR0 to RR3 read 0.
- R12: `bus_rdata` is registered. It takes the read value at the edge that samples a read and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Bit 0 = control/data, bit 1 = channel A/B |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 2 | Received byte offered, per channel |
| rx_byte | input | 16 | Received bytes, channel c at [8c+7:8c] |
| rx_ready | output | 2 | Channel can accept a received byte |
| tx_valid | output | 2 | One-cycle transmit strobe per channel |
| tx_data | output | 16 | Transmit bytes, channel c at [8c+7:8c] |
| cfg_valid | output | 2 | One-cycle pulse after a parameter recompute |
| cfg_div | output | 48 | Input clocks per bit, 24 bits per channel |
| cfg_bits | output | 8 | Character length, 4 bits per channel |
| cfg_two_stop | output | 2 | Two stop bits selected |
| cfg_par_en | output | 2 | Parity enabled |
| cfg_par_even | output | 2 | Even parity selected |

## Verification
If the pointer state is wrong, the very next control read shows it: a stuck pointer returns RR1 or RR2 where RR0 was expected. A swapped channel decode shows one access later as RR2 or RR3 values on the wrong channel. A wrong reset fan-out from WR9 shows as a `cfg_valid` pulse on the wrong channel one cycle after the write, and as a cleared RR2 that should have survived. If the status or pending state is wrong, `rx_ready` is off before the next byte is offered, or RR3 is off on the next pointer read. Every line output is compared after every configuration write, so a decode error shows within one cycle.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int DW    = 8;
  localparam int NREG  = 16;
  localparam int IDXW  = $clog2(NREG);
  localparam int NCH   = 2;
  localparam int BRGW  = 2 * DW;
  localparam int MAXSH = 7;                     // 2x base times 64 prescale
  localparam int DIVW  = BRGW + 1 + MAXSH;
  localparam int BITSW = 4;

  localparam int IX_STAT   = 0;
  localparam int IX_SPEC   = 1;
  localparam int IX_VECT   = 2;
  localparam int IX_PEND   = 3;
  localparam int IX_RXCFG  = 3;
  localparam int IX_FRAME  = 4;
  localparam int IX_TXCFG  = 5;
  localparam int IX_RESET  = 9;
  localparam int IX_BRG_LO = 12;
  localparam int IX_BRG_HI = 13;

  localparam logic [2:0] CMD_POINT_HIGH  = 3'd1;
  localparam logic [2:0] CMD_CLEAR_TX    = 3'd5;
  localparam logic [2:0] CMD_END_SERVICE = 3'd7;

  localparam logic [DW-1:0] STAT_INIT = 8'h44;
  localparam logic [DW-1:0] SPEC_INIT = 8'h07;

  typedef struct packed {
    logic [DIVW-1:0]  div;
    logic [BITSW-1:0] bits;
    logic             two_stop;
    logic             par_en;
    logic             par_even;
  } line_cfg_t;

  function automatic logic [DW-1:0] wr_init(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/scc_line_decode.sv
module scc_line_decode
  import scc_pkg::*;
(
  input  logic [DW-1:0] frame,
  input  logic [DW-1:0] txcfg,
  input  logic [DW-1:0] brg_lo,
  input  logic [DW-1:0] brg_hi,
  output line_cfg_t     cfg
);
  logic [BRGW:0] tc;
  logic [2:0]    sh;

  assign tc = {1'b0, brg_hi, brg_lo} + (BRGW+1)'(2);

  always_comb begin
    case (frame[7:6])
      2'b00:   sh = 3'd1;
      2'b01:   sh = 3'd5;
      2'b10:   sh = 3'd6;
      default: sh = 3'd7;
    endcase
    cfg.div = DIVW'(tc) << sh;
    case (txcfg[6:5])
      2'b00:   cfg.bits = BITSW'(5);
      2'b01:   cfg.bits = BITSW'(7);
      2'b10:   cfg.bits = BITSW'(6);
      default: cfg.bits = BITSW'(8);
    endcase
    cfg.two_stop = (frame[3:2] == 2'b11);
    cfg.par_en   = frame[0];
    cfg.par_even = frame[1];
  end
endmodule

// File: rtl/scc_channel.sv
module scc_channel
  import scc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          ctl_wr,
  input  logic          ctl_rd,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] rr3_in,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] rx_q,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          pend_tx,
  output logic          pend_rx,
  output logic [1:0]    rst_req,
  output line_cfg_t     cfg_q,
  output logic          cfg_valid
);
  localparam line_cfg_t CFG_INIT = '{div: DIVW'(4), bits: BITSW'(5),
                                     two_stop: 1'b0, par_en: 1'b0, par_even: 1'b0};

  logic [DW-1:0]   wreg_q [NREG];
  logic [DW-1:0]   stat_q, spec_q, vect_q, rxbuf_q;
  logic [IDXW-1:0] ptr_q;
  logic            upd_q;
  logic [2:0]      cmd;
  line_cfg_t       cfg_d;

  assign cmd      = wdata[5:3];
  assign rx_ready = wreg_q[IX_RXCFG][0] & ~stat_q[0];
  assign rx_q     = rxbuf_q;
  assign rst_req  = (ctl_wr && ptr_q == IDXW'(IX_RESET)) ? wdata[DW-1 -: 2] : 2'b00;

  always_comb begin
    case (ptr_q)
      IDXW'(IX_STAT): ctl_q = stat_q;
      IDXW'(IX_SPEC): ctl_q = spec_q;
      IDXW'(IX_VECT): ctl_q = vect_q;
      IDXW'(IX_PEND): ctl_q = rr3_in;
      default:        ctl_q = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      for (int i = 0; i < NREG; i++) wreg_q[i] <= wr_init(i);
      stat_q   <= STAT_INIT;
      spec_q   <= SPEC_INIT;
      vect_q   <= '0;
      rxbuf_q  <= '0;
      ptr_q    <= '0;
      pend_tx  <= 1'b0;
      pend_rx  <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      upd_q    <= soft_rst && !rst;
    end else begin
      upd_q    <= 1'b0;
      tx_valid <= 1'b0;
      if (ctl_wr) begin
        if (ptr_q == '0) begin
          ptr_q <= {cmd == CMD_POINT_HIGH, wdata[2:0]};
          if (cmd == CMD_CLEAR_TX) pend_tx <= 1'b0;
          else if (cmd == CMD_END_SERVICE) begin
            if (pend_rx) pend_rx <= 1'b0;
            else         pend_tx <= 1'b0;
          end
        end else begin
          wreg_q[ptr_q] <= wdata;
          ptr_q         <= '0;
          if (ptr_q == IDXW'(IX_VECT)) vect_q <= wdata;
          if (ptr_q == IDXW'(IX_FRAME) || ptr_q == IDXW'(IX_TXCFG) ||
              ptr_q == IDXW'(IX_BRG_LO) || ptr_q == IDXW'(IX_BRG_HI))
            upd_q <= 1'b1;
        end
      end
      if (ctl_rd && ptr_q != '0) ptr_q <= '0;
      if (dat_wr && wreg_q[IX_TXCFG][3]) begin
        tx_valid  <= 1'b1;
        tx_data   <= wdata;
        stat_q[2] <= 1'b1;
        spec_q[0] <= 1'b1;
        pend_tx   <= 1'b1;
      end
      if (dat_rd) stat_q[0] <= 1'b0;
      if (rx_valid && rx_ready) begin
        rxbuf_q   <= rx_byte;
        stat_q[0] <= 1'b1;
        pend_rx   <= 1'b1;
      end
    end
  end

  scc_line_decode i_dec (
    .frame (wreg_q[IX_FRAME]),
    .txcfg (wreg_q[IX_TXCFG]),
    .brg_lo(wreg_q[IX_BRG_LO]),
    .brg_hi(wreg_q[IX_BRG_HI]),
    .cfg   (cfg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= CFG_INIT;
      cfg_valid <= 1'b0;
    end else begin
      cfg_valid <= upd_q;
      if (upd_q) cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/scc_regif.sv
module scc_regif
  import scc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_cs,
  input  logic                  bus_we,
  input  logic [1:0]            bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [NCH-1:0]        rx_valid,
  input  logic [NCH*DW-1:0]     rx_byte,
  output logic [NCH-1:0]        rx_ready,
  output logic [NCH-1:0]        tx_valid,
  output logic [NCH*DW-1:0]     tx_data,
  output logic [NCH-1:0]        cfg_valid,
  output logic [NCH*DIVW-1:0]   cfg_div,
  output logic [NCH*BITSW-1:0]  cfg_bits,
  output logic [NCH-1:0]        cfg_two_stop,
  output logic [NCH-1:0]        cfg_par_en,
  output logic [NCH-1:0]        cfg_par_even
);
  logic [NCH-1:0] ctl_wr, ctl_rd, dat_wr, dat_rd;
  logic [NCH-1:0] soft_rst, pend_tx, pend_rx;
  logic [1:0]     rst_req [NCH];
  logic [DW-1:0]  ctl_q [NCH];
  logic [DW-1:0]  rx_q  [NCH];
  line_cfg_t      cfg   [NCH];
  logic [DW-1:0]  pend_view;

  // Bit 0 of the reset field targets channel B (index 0), bit 1 channel A.
  always_comb begin
    soft_rst = '0;
    for (int c = 0; c < NCH; c++) soft_rst = soft_rst | rst_req[c];
  end

  assign pend_view = {2'b00, pend_rx[1], pend_tx[1], 1'b0, pend_rx[0], pend_tx[0], 1'b0};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit       = bus_cs && (bus_addr[1] == c[0]);
    assign ctl_wr[c] = hit &&  bus_we && !bus_addr[0];
    assign ctl_rd[c] = hit && !bus_we && !bus_addr[0];
    assign dat_wr[c] = hit &&  bus_we &&  bus_addr[0];
    assign dat_rd[c] = hit && !bus_we &&  bus_addr[0];

    scc_channel i_chan (
      .clk      (clk),
      .rst      (rst),
      .soft_rst (soft_rst[c]),
      .ctl_wr   (ctl_wr[c]),
      .ctl_rd   (ctl_rd[c]),
      .dat_wr   (dat_wr[c]),
      .dat_rd   (dat_rd[c]),
      .wdata    (bus_wdata),
      .rx_valid (rx_valid[c]),
      .rx_byte  (rx_byte[c*DW +: DW]),
      .rr3_in   ((c == NCH-1) ? pend_view : '0),
      .ctl_q    (ctl_q[c]),
      .rx_q     (rx_q[c]),
      .rx_ready (rx_ready[c]),
      .tx_valid (tx_valid[c]),
      .tx_data  (tx_data[c*DW +: DW]),
      .pend_tx  (pend_tx[c]),
      .pend_rx  (pend_rx[c]),
      .rst_req  (rst_req[c]),
      .cfg_q    (cfg[c]),
      .cfg_valid(cfg_valid[c])
    );

    assign cfg_div[c*DIVW +: DIVW]    = cfg[c].div;
    assign cfg_bits[c*BITSW +: BITSW] = cfg[c].bits;
    assign cfg_two_stop[c]            = cfg[c].two_stop;
    assign cfg_par_en[c]              = cfg[c].par_en;
    assign cfg_par_even[c]            = cfg[c].par_even;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_cs && !bus_we)
      bus_rdata <= bus_addr[0] ? rx_q[bus_addr[1]] : ctl_q[bus_addr[1]];
  end
endmodule

// File: rtl/scc_regif_chk.sv
module scc_regif_chk
  import scc_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_cs,
  input logic                 bus_we,
  input logic [1:0]           bus_addr,
  input logic [DW-1:0]        bus_rdata,
  input logic [NCH-1:0]       rx_valid,
  input logic [NCH-1:0]       rx_ready,
  input logic [NCH-1:0]       tx_valid,
  input logic [NCH-1:0]       cfg_valid,
  input logic [NCH*DIVW-1:0]  cfg_div,
  input logic [NCH*BITSW-1:0] cfg_bits
);
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_cs && !bus_we) |=> $stable(bus_rdata));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r7_accept_closes: assert property (@(posedge clk) disable iff (rst)
      (rx_valid[c] && rx_ready[c]) |=> !rx_ready[c]);

    a_r6_tx_from_data_write: assert property (@(posedge clk) disable iff (rst)
      tx_valid[c] |-> $past(bus_cs && bus_we && bus_addr == 2'((c << 1) | 1)));

    a_r10_strobe_from_write: assert property (@(posedge clk) disable iff (rst)
      cfg_valid[c] |-> $past(bus_cs && bus_we && !bus_addr[0], 2));

    a_r9_div_floor: assert property (@(posedge clk) disable iff (rst)
      cfg_div[c*DIVW +: DIVW] >= DIVW'(4) && !cfg_div[c*DIVW]);

    a_r8_bits_range: assert property (@(posedge clk) disable iff (rst)
      cfg_bits[c*BITSW +: BITSW] >= BITSW'(5) && cfg_bits[c*BITSW +: BITSW] <= BITSW'(8));
  end
endmodule

bind scc_regif scc_regif_chk i_scc_regif_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_cs   (bus_cs),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .tx_valid (tx_valid),
  .cfg_valid(cfg_valid),
  .cfg_div  (cfg_div),
  .cfg_bits (cfg_bits)
);

// File: tb/test_scc_regif.sv
`timescale 1ns/1ps
module test_scc_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'b00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [1:0]  rx_valid = 2'b00;
  logic [15:0] rx_byte = 16'h0;
  wire  [7:0]  bus_rdata;
  wire  [1:0]  rx_ready, tx_valid, cfg_valid, cfg_two_stop, cfg_par_en, cfg_par_even;
  wire  [15:0] tx_data;
  wire  [47:0] cfg_div;
  wire  [7:0]  cfg_bits;

  always #2.5 clk = ~clk;

  scc_regif i_scc_regif (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .cfg_valid(cfg_valid),
    .cfg_div(cfg_div), .cfg_bits(cfg_bits), .cfg_two_stop(cfg_two_stop),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even)
  );

  int nvec = 0, nfail = 0;

  logic [7:0] m_wr [2][16];
  logic [7:0] m_rr0 [2], m_rr1 [2], m_rr2 [2], m_rx [2];
  bit         m_ptx [2], m_prx [2];
  int         m_div [2], m_bits [2];
  bit         m_two [2], m_pe [2], m_pev [2];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int calc_div(input int c);
    int n, p;
    n = {m_wr[c][13], m_wr[c][12]};
    case (m_wr[c][4][7:6])
      2'd0: p = 1;
      2'd1: p = 16;
      2'd2: p = 32;
      default: p = 64;
    endcase
    return 2 * (n + 2) * p;
  endfunction

  function automatic int calc_bits(input int c);
    case (m_wr[c][5][6:5])
      2'd0: return 5;
      2'd1: return 7;
      2'd2: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic void snap(input int c);
    m_div[c]  = calc_div(c);
    m_bits[c] = calc_bits(c);
    m_two[c]  = (m_wr[c][4][3:2] == 2'b11);
    m_pe[c]   = m_wr[c][4][0];
    m_pev[c]  = m_wr[c][4][1];
  endfunction

  function automatic void m_reset(input int c);
    for (int i = 0; i < 16; i++) m_wr[c][i] = 8'h00;
    m_wr[c][4] = 8'h04; m_wr[c][9] = 8'hC0; m_wr[c][11] = 8'h08;
    m_wr[c][14] = 8'h30; m_wr[c][15] = 8'hF8;
    m_rr0[c] = 8'h44; m_rr1[c] = 8'h07; m_rr2[c] = 8'h00; m_rx[c] = 8'h00;
    m_ptx[c] = 0; m_prx[c] = 0;
    snap(c);
  endfunction

  function automatic logic [7:0] exp_rr(input int c, input int idx);
    case (idx)
      0: return m_rr0[c];
      1: return m_rr1[c];
      2: return m_rr2[c];
      3: return (c == 1) ? {2'b00, m_prx[1], m_ptx[1], 1'b0, m_prx[0], m_ptx[0], 1'b0} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk_cfg(input int c);
    check("R9 divisor", cfg_div[c*24 +: 24], m_div[c]);
    check("R8 data bits", cfg_bits[c*4 +: 4], m_bits[c]);
    check("R8 two stop", cfg_two_stop[c], m_two[c]);
    check("R8 parity enable", cfg_par_en[c], m_pe[c]);
    check("R8 parity even", cfg_par_even[c], m_pev[c]);
  endtask

  task automatic bus_op(input bit we, input int ch, input bit dat, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = we; bus_addr = {ch[0], dat}; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic ptr_set(input int ch, input int idx);
    bus_op(1, ch, 0, (idx >= 8) ? (8'h08 | 8'(idx & 7)) : 8'(idx));
  endtask

  task automatic wreg(input int ch, input int idx, input logic [7:0] val);
    logic [1:0] tgt;
    bit recomp;
    tgt = 2'b00; recomp = 0;
    ptr_set(ch, idx);
    bus_op(1, ch, 0, val);
    if (idx == 9) begin
      tgt = val[7:6];
      for (int c = 0; c < 2; c++) if (tgt[c]) m_reset(c);
      if (!tgt[ch]) m_wr[ch][9] = val;
    end else begin
      m_wr[ch][idx] = val;
      if (idx == 2) m_rr2[ch] = val;
      if (idx == 4 || idx == 5 || idx == 12 || idx == 13) begin
        snap(ch); recomp = 1;
      end
    end
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      check("R10 cfg_valid strobe", cfg_valid[c], ((c == ch) && recomp) || tgt[c]);
      chk_cfg(c);
    end
  endtask

  task automatic rreg(input string tag, input int ch, input int idx);
    ptr_set(ch, idx);
    bus_op(0, ch, 0, 8'h00);
    check(tag, bus_rdata, exp_rr(ch, idx));
  endtask

  task automatic dwrite(input int ch, input logic [7:0] v);
    bit en;
    en = m_wr[ch][5][3];
    bus_op(1, ch, 1, v);
    check("R6 tx strobe", tx_valid, en ? (2'b01 << ch) : 2'b00);
    if (en) begin
      check("R6 tx byte", tx_data[ch*8 +: 8], v);
      m_rr0[ch][2] = 1'b1; m_rr1[ch][0] = 1'b1; m_ptx[ch] = 1;
    end
  endtask

  task automatic dread(input int ch);
    bus_op(0, ch, 1, 8'h00);
    check("R7 data read", bus_rdata, m_rx[ch]);
    m_rr0[ch][0] = 1'b0;
  endtask

  task automatic rpush(input int ch, input logic [7:0] v);
    bit ok;
    ok = m_wr[ch][3][0] && !m_rr0[ch][0];
    @(negedge clk);
    check("R7 rx_ready", rx_ready[ch], ok);
    rx_valid[ch] = 1'b1; rx_byte[ch*8 +: 8] = v;
    @(negedge clk);
    rx_valid = 2'b00;
    if (ok) begin
      m_rx[ch] = v; m_rr0[ch][0] = 1'b1; m_prx[ch] = 1;
    end
  endtask

  task automatic cmd(input int ch, input logic [7:0] v);
    bus_op(1, ch, 0, v);
    if (v[5:3] == 3'd5) m_ptx[ch] = 0;
    else if (v[5:3] == 3'd7) begin
      if (m_prx[ch]) m_prx[ch] = 0;
      else m_ptx[ch] = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int wl [6] = '{2, 3, 4, 5, 12, 13};
    int rl [6] = '{0, 1, 2, 3, 6, 12};
    logic [7:0] hold;
    void'($urandom(32'd7091));
    m_reset(0); m_reset(1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R5: state after hard reset
    check("R5 rdata after reset", bus_rdata, 8'h00);
    check("R5 cfg_valid idle", cfg_valid, 2'b00);
    check("R5 rx_ready idle", rx_ready, 2'b00);
    check("R5 tx_valid idle", tx_valid, 2'b00);
    chk_cfg(0); chk_cfg(1);
    rreg("R5 RR0 A", 1, 0);
    rreg("R5 RR1 B", 0, 1);
    rreg("R5 RR3 A", 1, 3);
    rreg("R11 RR3 B zero", 0, 3);
    rreg("R11 RR7 zero", 1, 7);

    // R2: pointer returns to zero after a nonzero access
    ptr_set(1, 1);
    bus_op(0, 1, 0, 8'h00);
    check("R2 pointed read RR1", bus_rdata, 8'h07);
    bus_op(0, 1, 0, 8'h00);
    check("R2 pointer back to RR0", bus_rdata, 8'h44);

    // R2/R9/R8: point-high reaches the divisor registers
    wreg(1, 12, 8'h10);
    wreg(1, 13, 8'h01);
    wreg(1, 4, 8'h4D);
    wreg(1, 5, 8'h68);
    rreg("R11 RR12 zero via point-high", 1, 12);
    bus_op(0, 1, 0, 8'h00);
    check("R2 RR0 after high read", bus_rdata, 8'h44);

    // R11 and R1: mirror stays in its own channel
    wreg(0, 2, 8'h5A);
    rreg("R11 RR2 mirror", 0, 2);
    rreg("R1 other channel RR2", 1, 2);

    // R6: transmit gating and pending
    dwrite(0, 8'h11);
    dwrite(1, 8'hA5);
    rreg("R3 A tx pending", 1, 3);
    rreg("R6 RR1 all sent", 1, 1);

    // R12: rdata holds across a write
    hold = bus_rdata;
    bus_op(1, 0, 1, 8'h22);
    @(negedge clk);
    check("R12 rdata hold", bus_rdata, hold);

    // R7: receive gating
    rpush(1, 8'h3C);
    dread(1);
    wreg(1, 3, 8'h01);
    rpush(1, 8'h3C);
    rpush(1, 8'h77);
    rreg("R7 RR0 rx avail", 1, 0);
    rreg("R3 both pending", 1, 3);
    cmd(1, 8'h38);
    rreg("R3 end service clears rx first", 1, 3);
    cmd(1, 8'h38);
    rreg("R3 end service then tx", 1, 3);
    dread(1);
    rreg("R7 avail cleared", 1, 0);
    dwrite(1, 8'h5E);
    cmd(1, 8'h28);
    rreg("R3 clear tx command", 1, 3);

    // R4: reset commands
    wreg(1, 2, 8'h22);
    wreg(1, 9, 8'h40);
    rreg("R4 B reset clears RR2", 0, 2);
    rreg("R4 A untouched by B reset", 1, 2);
    wreg(0, 9, 8'h80);
    rreg("R4 A reset clears RR2", 1, 2);
    rreg("R5 RR0 after channel reset", 1, 0);
    wreg(1, 2, 8'h33);
    wreg(1, 9, 8'h00);
    rreg("R4 null reset keeps RR2", 1, 2);
    wreg(0, 2, 8'h44);
    wreg(0, 9, 8'hC0);
    rreg("R4 both reset A", 1, 2);
    rreg("R4 both reset B", 0, 2);

    // random mix
    for (int k = 0; k < 500; k++) begin
      int ch, op;
      ch = $urandom % 2;
      op = $urandom % 6;
      case (op)
        0: wreg(ch, wl[$urandom % 6], 8'($urandom));
        1: dwrite(ch, 8'($urandom));
        2: dread(ch);
        3: rpush(ch, 8'($urandom));
        4: rreg("R2 random register read", ch, rl[$urandom % 6]);
        default: cmd(ch, ($urandom % 2) ? 8'h28 : 8'h38);
      endcase
    end
    rreg("R3 final pending", 1, 3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule